// File: doc/BRIEF.md
# Multi-Crate Test Start Barrier

Several crates take part in one auto-test run and share one open-drain line. Each crate pulls the line low with an output enable. Once software arms the crate, it lets go of the line and waits. The line floats high only when every crate has let go, so the line acts as a wired-AND barrier. A crate that sees the line high for long enough begins the test. The crate strapped as master also raises the excitation enable for the high-voltage supply shared by all crates. Every crate reads the same wire, so no crate can begin before the master.

The line input is asynchronous, so it passes through a two-stage synchronizer. A high level counts only after a programmable number of consecutive high samples. This filters out glitches. A crate that waits longer than a programmable timeout pulls the line low again, drops back to idle and raises a failure flag. When the test ends, the crate pulls the line low again, which blocks the next run until all crates re-arm.

Top module: `tsync_start_barrier`

## Requirements
- R1: During and right after a synchronous reset, `line_oe_o`=1 (line pulled low), and `run_o`, `start_o`, `excite_o` and `fail_o` are all 0.
- R2: In the idle state `line_oe_o` stays 1. An `arm_i` pulse moves the crate to the wait state. From the next cycle `line_oe_o`=0 and `fail_o`=0.
- R3: `line_i` is sampled through two register stages. A level on `line_i` affects decisions no earlier than the third clock edge after it appears.
- R4: In the wait state, the test begins when the synchronized line has been high for `filt_len_i` consecutive samples (a value of 0 is treated as 1). `start_o` then pulses for exactly one cycle, the first cycle in which `run_o`=1. A low sample restarts the count.
- R5: `excite_o` rises together with `run_o` only when `master_i`=1. With `master_i`=0 it stays 0.
- R6: The wait state lasts at most `timeout_i` cycles (0 treated as 1). When it expires without a start, the crate returns to idle with `line_oe_o`=1 and `fail_o`=1.
- R7: If the start condition and the timeout fall in the same cycle, the start wins: `run_o`=1 and `fail_o` stays 0.
- R8: A `done_i` pulse while running returns the crate to idle. In the next cycle `line_oe_o`=1, `run_o`=0 and `excite_o`=0.
- R9: `arm_i` has no effect outside the idle state, and `done_i` has no effect outside the running state.
- R10: `fail_o` holds its value until the next accepted `arm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | Strap: this crate drives the shared excitation |
| arm_i | input | 1 | Arm request, accepted in idle |
| done_i | input | 1 | Test finished, accepted while running |
| filt_len_i | input | FILT_W | Consecutive high samples needed to start |
| timeout_i | input | TMO_W | Maximum wait length in cycles |
| line_i | input | 1 | Asynchronous level of the shared line |
| line_oe_o | output | 1 | 1 pulls the shared line low, 0 releases it |
| run_o | output | 1 | Test running |
| start_o | output | 1 | One-cycle pulse at test begin |
| excite_o | output | 1 | Excitation enable (master only) |
| fail_o | output | 1 | Synchronization timeout flag |

## Verification
The glitch-filter completion and the wait timeout can land on the same clock edge. The bench provokes this by leaving the other crates released and setting the filter length to one and the timeout to three cycles. That places the first synchronized high sample exactly on the last wait cycle. The run is judged by whether the crate enters running with no failure flag. A behavioural model, stepped with the line level it derives from its own and the other crates' drives, predicts every output on every cycle.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } tsync_state_e;

    typedef struct packed {
        logic start;
        logic excite;
        logic fail;
    } tsync_flags_t;

    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/tsync_sync.sv
module tsync_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[k] <= 1'b0;
                else     pipe[k] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[k] <= 1'b0;
                else     pipe[k] <= pipe[k-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/tsync_win_cnt.sv
module tsync_win_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt;
    logic [W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    assign hit_o    = cnt_next >= {1'b0, limit_i};

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt <= '0;
        else if (inc_i && (cnt != {W{1'b1}}))
            cnt <= cnt_next[W-1:0];
    end
endmodule

// File: rtl/tsync_start_barrier.sv
module tsync_start_barrier
    import tsync_pkg::*;
#(
    parameter int unsigned FILT_W      = 8,
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_i,
    input  logic              arm_i,
    input  logic              done_i,
    input  logic [FILT_W-1:0] filt_len_i,
    input  logic [TMO_W-1:0]  timeout_i,
    input  logic              line_i,
    output logic              line_oe_o,
    output logic              run_o,
    output logic              start_o,
    output logic              excite_o,
    output logic              fail_o
);
    tsync_state_e st;
    tsync_flags_t flg;
    logic         line_s;
    logic         hi_hit;
    logic         to_hit;
    logic         go;
    logic         expire;

    tsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d_i (line_i), .q_o (line_s)
    );

    tsync_win_cnt #(.W(FILT_W)) u_hi_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr_i   ((st != ST_WAIT) || !line_s),
        .inc_i   (1'b1),
        .limit_i (filt_len_i),
        .hit_o   (hi_hit)
    );

    tsync_win_cnt #(.W(TMO_W)) u_wait_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (st != ST_WAIT),
        .inc_i   (1'b1),
        .limit_i (timeout_i),
        .hit_o   (to_hit)
    );

    assign go     = (st == ST_WAIT) && line_s && hi_hit;
    assign expire = (st == ST_WAIT) && to_hit && !go;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            flg <= '0;
        end else begin
            flg.start <= 1'b0;
            unique case (st)
                ST_IDLE: if (arm_i) begin
                    st       <= ST_WAIT;
                    flg.fail <= 1'b0;
                end
                ST_WAIT: if (go) begin
                    st         <= ST_RUN;
                    flg.start  <= 1'b1;
                    flg.excite <= master_i;
                end else if (expire) begin
                    st       <= ST_IDLE;
                    flg.fail <= 1'b1;
                end
                ST_RUN: if (done_i) begin
                    st         <= ST_IDLE;
                    flg.excite <= 1'b0;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign line_oe_o = (st == ST_IDLE);
    assign run_o     = (st == ST_RUN);
    assign start_o   = flg.start;
    assign excite_o  = flg.excite;
    assign fail_o    = flg.fail;

    assert_arm_release_R2: assert property (@(posedge clk) disable iff (rst)
        (line_oe_o && arm_i) |=> (!line_oe_o && !fail_o));

    assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    assert_run_has_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(run_o) |-> start_o);

    assert_slave_no_excite_R5: assert property (@(posedge clk) disable iff (rst)
        (go && !master_i) |=> !excite_o);

    assert_timeout_exit_R6: assert property (@(posedge clk) disable iff (rst)
        expire |=> (line_oe_o && fail_o));

    assert_start_beats_timeout_R7: assert property (@(posedge clk) disable iff (rst)
        (go && to_hit) |=> (run_o && !fail_o));

    assert_done_release_R8: assert property (@(posedge clk) disable iff (rst)
        (run_o && done_i) |=> (line_oe_o && !run_o && !excite_o));

    assert_fail_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (fail_o && !(line_oe_o && arm_i)) |=> fail_o);
endmodule

// File: tb/tsync_start_barrier_tb_top.sv
module tsync_start_barrier_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master = 1'b1;
    logic        arm = 1'b0;
    logic        done = 1'b0;
    logic [7:0]  filt = 8'd3;
    logic [15:0] tmo = 16'd40;
    logic        oth_a = 1'b1;
    logic        oth_b = 1'b1;
    logic        line;
    logic        oe, run, start, excite, fail;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_en = 1'b0;
    string cur_req = "R1";

    // model state
    int m_st = 0, m_hi = 0, m_wc = 0;
    bit m_start = 0, m_fail = 0, m_exc = 0, m_s1 = 0, m_s2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line = !(oe || oth_a || oth_b);

    tsync_start_barrier dut_i (
        .clk (clk), .rst (rst), .master_i (master), .arm_i (arm), .done_i (done),
        .filt_len_i (filt), .timeout_i (tmo), .line_i (line),
        .line_oe_o (oe), .run_o (run), .start_o (start), .excite_o (excite), .fail_o (fail)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference, stepped on each rising edge
    always @(posedge clk) begin
        bit line_now;
        int lim_f, lim_t;
        line_now = !((m_st == 0) || oth_a || oth_b);
        lim_f = (filt == 0) ? 1 : int'(filt);
        lim_t = (tmo == 0) ? 1 : int'(tmo);
        if (rst) begin
            m_st = 0; m_start = 0; m_fail = 0; m_exc = 0;
            m_hi = 0; m_wc = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_start = 0;
            if (m_st == 0) begin
                if (arm) begin m_st = 1; m_fail = 0; m_hi = 0; m_wc = 0; end
            end else if (m_st == 1) begin
                if (m_s2 && (m_hi + 1 >= lim_f)) begin
                    m_st = 2; m_start = 1; m_exc = master;
                end else if (m_wc + 1 >= lim_t) begin
                    m_st = 0; m_fail = 1;
                end else begin
                    m_hi = m_s2 ? m_hi + 1 : 0;
                    m_wc++;
                end
            end else begin
                if (done) begin m_st = 0; m_exc = 0; end
            end
            m_s2 = m_s1;   // R3: two sampling stages
            m_s1 = line_now;
        end
    end

    // per-cycle comparison away from the rising edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check({cur_req, " oe"},     int'(oe),     int'(m_st == 0));
            check({cur_req, " run"},    int'(run),    int'(m_st == 2));
            check({cur_req, " start"},  int'(start),  int'(m_start));
            check({cur_req, " excite"}, int'(excite), int'(m_exc));
            check({cur_req, " fail"},   int'(fail),   int'(m_fail));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_arm();
        arm = 1'b1; tick(1); arm = 1'b0;
    endtask

    task automatic pulse_done();
        done = 1'b1; tick(1); done = 1'b0;
    endtask

    initial begin
        @(posedge clk);
        cmp_en = 1'b1;
        tick(3);
        cur_req = "R1";
        check("R1 oe in reset", int'(oe), 1);
        check("R1 run in reset", int'(run), 0);
        rst = 1'b0;
        tick(1);
        check("R1 fail after reset", int'(fail), 0);

        // arm, others join late
        cur_req = "R2";
        tick(2);
        check("R2 idle keeps line low", int'(oe), 1);
        pulse_arm();
        check("R2 released after arm", int'(oe), 0);
        cur_req = "R4";
        tick(3); oth_a = 1'b0;
        tick(2); oth_b = 1'b0;
        tick(10);
        check("R4 running after filter", int'(run), 1);
        check("R5 master excites", int'(excite), 1);

        cur_req = "R9";
        pulse_arm();
        check("R9 arm ignored while running", int'(run), 1);

        cur_req = "R8";
        pulse_done();
        check("R8 line low after done", int'(oe), 1);
        check("R8 excite off after done", int'(excite), 0);

        cur_req = "R9";
        pulse_done();
        check("R9 done ignored in idle", int'(oe), 1);
        oth_a = 1'b1;
        pulse_arm();
        pulse_done();
        check("R9 done ignored while waiting", int'(oe), 0);

        // glitch shorter than filter
        cur_req = "R4";
        filt = 8'd4;
        oth_a = 1'b0; tick(2); oth_a = 1'b1;
        tick(6);
        check("R4 glitch rejected", int'(run), 0);
        oth_a = 1'b0;
        tick(10);
        check("R4 steady high starts", int'(run), 1);
        pulse_done();

        // timeout
        cur_req = "R6";
        tmo = 16'd10; oth_a = 1'b1;
        pulse_arm();
        tick(15);
        check("R6 fail after timeout", int'(fail), 1);
        check("R6 line low after timeout", int'(oe), 1);
        cur_req = "R10";
        tick(5);
        check("R10 fail held", int'(fail), 1);
        pulse_arm();
        check("R10 fail cleared by arm", int'(fail), 0);
        tick(15);

        // slave crate
        cur_req = "R5";
        master = 1'b0; oth_a = 1'b0; tmo = 16'd40; filt = 8'd2;
        pulse_arm();
        tick(10);
        check("R5 slave runs", int'(run), 1);
        check("R5 slave no excite", int'(excite), 0);
        pulse_done();

        // start and timeout on the same edge
        cur_req = "R7";
        master = 1'b1; filt = 8'd1; tmo = 16'd3;
        tick(2);
        pulse_arm();
        tick(6);
        check("R7 start wins run", int'(run), 1);
        check("R7 start wins no fail", int'(fail), 0);
        pulse_done();
        tick(3);

        cmp_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule